// File: doc/BRIEF.md
# Horizontal Pan Position Tracker

This block keeps the horizontal scroll position of a display viewport that shows part of a wider virtual image. Each screen has its own position, made of a word start address and a sub-word pixel offset. Software or a scroll engine moves the view one pixel at a time with pan-left and pan-right requests, and a screen-select input chooses which screen a request moves. A write port can load a position directly.

The colour depth selector sets how many pixels share one memory word, and so where the pixel offset ends and the start address begins. At deep colour depths there is no pixel offset, and every step moves the start address. The block drives both start addresses. It also drives an 8-bit pixel panning value that carries one 4-bit offset field per screen.

Top module: `pan_tracker`

## Requirements
- R1: The `depth` code selects pixels per word: 0 gives 16 (1 bpp), 1 gives 8 (2 bpp), 2 gives 4 (4 bpp), 3 gives 2 (8 bpp), and 4 or 5 give 1 (15 or 16 bpp). A pixel offset runs from 0 to pixels-per-word minus one.
- R2: `pan_reg[3:0]` holds the screen A offset and `pan_reg[7:4]` holds the screen B offset. Offset bits above the range of the current depth read as zero.
- R3: A pan-right step adds one to the offset. From the last pixel of a word it returns the offset to 0 and adds one to the start address.
- R4: At depth codes 4 and 5, every step changes the start address by one and the offset stays zero.
- R5: A pan-left step subtracts one from the offset. From offset 0 it sets the offset to pixels-per-word minus one and subtracts one from the start address. At address 0 with offset 0 the position holds.
- R6: When pan-left and pan-right are both high in the same cycle, neither screen's position changes.
- R7: At the all-ones start address with the offset at its last pixel, a pan-right step holds the position.
- R8: A change of `depth` clears both offset fields and keeps both start addresses. A step requested in the same cycle is dropped.
- R9: A step moves only the screen chosen by `scr_sel` (0 selects A, 1 selects B). The other screen's position stays unchanged.
- R10: A write loads `wr_addr` and `wr_pan` into the screen chosen by `wr_scr`. The offset is masked to the active bits of the current depth. A write takes priority over a step and over a depth-change clear on that screen.
- R11: Reset clears every position. A step, write or clear shows on the outputs one clock after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pan_left | input | 1 | Single-pixel pan-left request |
| pan_right | input | 1 | Single-pixel pan-right request |
| scr_sel | input | 1 | Screen that a step moves (0 = A, 1 = B) |
| depth | input | 3 | Colour depth code |
| wr_en | input | 1 | Position preset strobe |
| wr_scr | input | 1 | Screen that a preset loads |
| wr_addr | input | AW | Preset start address |
| wr_pan | input | 4 | Preset pixel offset |
| start_addr_a | output | AW | Screen A word start address |
| start_addr_b | output | AW | Screen B word start address |
| pan_reg | output | 8 | Pixel panning value, screen B in [7:4] and screen A in [3:0] |

## Verification
The bench sweeps every depth code. At each one it steps across word boundaries in both directions and compares the outputs against a linear position worked out arithmetically. A tracker that carried at the wrong pixel count would move the start address too early or too late, and a wrong borrow would leave a stale offset. The bench drives the left floor and the all-ones ceiling, where a wrapping design would jump to the opposite end. It also drives simultaneous left and right requests, where a design that favours one direction would move. Further cases cover a depth change together with a step, masked writes, and a step on one screen while the other is watched; these catch a design that kept a stale offset, leaked unused bits or moved the wrong screen.

// File: rtl/pan_tracker.sv
module pan_tracker #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pan_left,
  input  logic          pan_right,
  input  logic          scr_sel,
  input  logic [2:0]    depth,
  input  logic          wr_en,
  input  logic          wr_scr,
  input  logic [AW-1:0] wr_addr,
  input  logic [3:0]    wr_pan,
  output logic [AW-1:0] start_addr_a,
  output logic [AW-1:0] start_addr_b,
  output logic [7:0]    pan_reg
);

  logic [2:0]    depth_q;
  logic [3:0]    mask;
  logic [AW-1:0] addr_r [2];
  logic [3:0]    pix_r  [2];

  always_comb begin
    case (depth)
      3'd0:    mask = 4'hF;
      3'd1:    mask = 4'h7;
      3'd2:    mask = 4'h3;
      3'd3:    mask = 4'h1;
      default: mask = 4'h0;
    endcase
  end

  wire depth_chg = (depth != depth_q);
  wire step      = pan_left ^ pan_right;

  always_ff @(posedge clk) begin
    if (!rst_n) depth_q <= 3'd0;
    else        depth_q <= depth;
  end

  for (genvar s = 0; s < 2; s++) begin : g_scr
    wire mine_wr   = wr_en && (wr_scr == 1'(s));
    wire mine_step = step && (scr_sel == 1'(s));
    wire at_top    = (pix_r[s] == mask) && (addr_r[s] == {AW{1'b1}});
    wire at_bot    = (pix_r[s] == 4'd0) && (addr_r[s] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_r[s] <= '0;
        pix_r[s]  <= 4'd0;
      end else if (mine_wr) begin
        addr_r[s] <= wr_addr;
        pix_r[s]  <= wr_pan & mask;
      end else if (depth_chg) begin
        pix_r[s]  <= 4'd0;
      end else if (mine_step) begin
        if (pan_right && !at_top) begin
          if (pix_r[s] == mask) begin
            pix_r[s]  <= 4'd0;
            addr_r[s] <= addr_r[s] + 1'b1;
          end else begin
            pix_r[s]  <= pix_r[s] + 4'd1;
          end
        end else if (pan_left && !at_bot) begin
          if (pix_r[s] == 4'd0) begin
            pix_r[s]  <= mask;
            addr_r[s] <= addr_r[s] - 1'b1;
          end else begin
            pix_r[s]  <= pix_r[s] - 4'd1;
          end
        end
      end
    end
  end

  assign start_addr_a = addr_r[0];
  assign start_addr_b = addr_r[1];
  assign pan_reg      = {pix_r[1], pix_r[0]};

endmodule

// File: rtl/pan_tracker_chk.sv
module pan_tracker_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pan_left,
  input logic          pan_right,
  input logic          scr_sel,
  input logic [2:0]    depth,
  input logic [2:0]    depth_q,
  input logic          wr_en,
  input logic [AW-1:0] start_addr_a,
  input logic [AW-1:0] start_addr_b,
  input logic [7:0]    pan_reg
);

  function automatic logic [3:0] active(input logic [2:0] d);
    case (d)
      3'd0:    return 4'hF;
      3'd1:    return 4'h7;
      3'd2:    return 4'h3;
      3'd3:    return 4'h1;
      default: return 4'h0;
    endcase
  endfunction

  wire quiet = !wr_en && (depth == depth_q);

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((pan_reg[3:0] & ~active(depth_q)) == 4'd0) &&
    ((pan_reg[7:4] & ~active(depth_q)) == 4'd0));

  a_r6_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pan_left && pan_right && quiet) |=>
      ($stable(start_addr_a) && $stable(start_addr_b) && $stable(pan_reg)));

  a_r8_depth_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (depth != depth_q && !wr_en) |=>
      (pan_reg == 8'd0 && $stable(start_addr_a) && $stable(start_addr_b)));

  a_r5_floor_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pan_left && !pan_right && quiet && !scr_sel &&
     start_addr_a == '0 && pan_reg[3:0] == 4'd0) |=>
      (start_addr_a == '0 && pan_reg[3:0] == 4'd0));

  a_r4_wide_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pan_right && !pan_left && quiet && depth >= 3'd4 && !scr_sel &&
     start_addr_a != {AW{1'b1}}) |=>
      (start_addr_a == $past(start_addr_a) + 1'b1 && pan_reg[3:0] == 4'd0));

  a_r9_other_screen: assert property (@(posedge clk) disable iff (!rst_n)
    ((pan_left ^ pan_right) && quiet && !scr_sel) |=>
      ($stable(start_addr_b) && $stable(pan_reg[7:4])));

endmodule

bind pan_tracker pan_tracker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pan_left(pan_left), .pan_right(pan_right),
  .scr_sel(scr_sel), .depth(depth), .depth_q(depth_q), .wr_en(wr_en),
  .start_addr_a(start_addr_a), .start_addr_b(start_addr_b), .pan_reg(pan_reg)
);

// File: tb/pan_tracker_bench.sv
module pan_tracker_bench;
  localparam int AW = 20;
  localparam longint MAXA = (longint'(1) << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pan_left = 1'b0, pan_right = 1'b0, scr_sel = 1'b0;
  logic [2:0]    depth = 3'd0;
  logic          wr_en = 1'b0, wr_scr = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [3:0]    wr_pan = 4'd0;
  logic [AW-1:0] start_addr_a, start_addr_b;
  logic [7:0]    pan_reg;

  int     tests = 0, fails = 0;
  longint ma [2];
  longint mp [2];
  int     cur_d = 0;

  always #4 clk = ~clk;

  pan_tracker #(.AW(AW)) u_pan_tracker (
    .clk(clk), .rst_n(rst_n), .pan_left(pan_left), .pan_right(pan_right),
    .scr_sel(scr_sel), .depth(depth), .wr_en(wr_en), .wr_scr(wr_scr),
    .wr_addr(wr_addr), .wr_pan(wr_pan), .start_addr_a(start_addr_a),
    .start_addr_b(start_addr_b), .pan_reg(pan_reg)
  );

  function automatic int ppw(input int d);
    return (d < 4) ? (1 << (4 - d)) : 1;
  endfunction

  task automatic check(input string tag);
    logic [AW-1:0] ea, eb;
    logic [7:0]    ep;
    ea = AW'(ma[0]);
    eb = AW'(ma[1]);
    ep = {4'(mp[1]), 4'(mp[0])};
    tests++;
    if (start_addr_a !== ea || start_addr_b !== eb || pan_reg !== ep) begin
      fails++;
      $display("FAIL %s: addr_a=%0d exp %0d, addr_b=%0d exp %0d, pan=%02h exp %02h",
               tag, start_addr_a, ea, start_addr_b, eb, pan_reg, ep);
    end
  endtask

  task automatic set_depth(input int d, input logic with_step);
    depth = 3'(d);
    pan_right = with_step;
    scr_sel = 1'b0;
    @(negedge clk);
    pan_right = 1'b0;
    if (d != cur_d) begin
      mp[0] = 0;
      mp[1] = 0;
    end
    cur_d = d;
    check("R8");
  endtask

  task automatic wr(input int s, input longint a, input int p);
    wr_en = 1'b1;
    wr_scr = 1'(s);
    wr_addr = AW'(a);
    wr_pan = 4'(p);
    @(negedge clk);
    wr_en = 1'b0;
    ma[s] = a;
    mp[s] = longint'(p & (ppw(cur_d) - 1));
    check("R10");
  endtask

  task automatic step(input logic l, input logic r, input int s, input string tag);
    longint pos, maxpos, n;
    pan_left = l;
    pan_right = r;
    scr_sel = 1'(s);
    @(negedge clk);
    pan_left = 1'b0;
    pan_right = 1'b0;
    if (l ^ r) begin
      n = longint'(ppw(cur_d));
      pos = ma[s] * n + mp[s];
      maxpos = (MAXA + 1) * n - 1;
      if (r && pos < maxpos) pos++;
      if (l && pos > 0) pos--;
      ma[s] = pos / n;
      mp[s] = pos % n;
    end
    check(tag);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    ma[0] = 0; ma[1] = 0; mp[0] = 0; mp[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11");

    for (int d = 0; d < 6; d++) begin
      int n;
      n = ppw(d);
      set_depth(d, 1'b0);
      wr(0, 3, 0);
      wr(1, 100, n - 1);
      repeat (2 * n + 1) step(0, 1, 0, (d >= 4) ? "R4" : "R3");
      repeat (4 * n + 3) step(1, 0, 0, "R5");
      repeat (n + 2) step(0, 1, 1, "R9");
      repeat (n + 1) step(1, 0, 1, "R9");
      step(1, 1, 0, "R6");
      step(1, 1, 1, "R6");
      wr(0, MAXA, (n > 1) ? n - 2 : 0);
      repeat (3) step(0, 1, 0, "R7");
      wr(0, 0, 0);
      repeat (n) step(0, 1, 0, "R1");
    end

    set_depth(3, 1'b0);
    wr(0, 5, 15);
    tests++;
    if (pan_reg[3:1] !== 3'd0) begin
      fails++;
      $display("FAIL R2: pan_reg=%02h exp upper bits zero", pan_reg);
    end
    wr(1, 9, 15);
    check("R2");

    set_depth(2, 1'b0);
    wr(0, 7, 3);
    wr(1, 11, 2);
    set_depth(0, 1'b1);
    check("R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule